// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers the request flags of an 8-bit microcontroller core: two external request lines, two timer overflow flags and the receive and transmit flags of a serial port. The two serial flags are merged into one request, so six flags are served through five vectors. A master enable, one enable bit per request and one priority bit per request decide which request is offered to the core. The core reads and writes the enable and priority registers as bytes, or one bit at a time through a bit address.

Flags are captured only on a latch strobe, which the core issues at the fixed sampling point late in every machine cycle. Arbitration runs on a later poll strobe, issued in the following machine cycle. A request at the high level beats any request at the low level. Inside one level the order is fixed: external 0, timer 0, external 1, timer 1, serial. The winner is held as a vector address with a request line until the core acknowledges it. The acknowledge marks its level as in service. A return-from-interrupt pulse ends the most recently entered level.

The control state machine has two states. `ST_IDLE` evaluates the latched requests on each poll strobe. It takes the transition *grant* to `ST_REQ` when a request may be taken, and captures the winner's vector and level on that transition. `ST_REQ` drives `irq_req` and holds the vector. It takes the transition *accept* back to `ST_IDLE` on `irq_ack`, and on that transition sets the in-service flag of the granted level.

Top module: `vic_ctrl`

## Requirements
- R1: After reset the enable register (address A8h) and the priority register (address B8h) both read 00h, and `irq_req` is 0.
- R2: When enable bit 7 (global) is 0, no poll raises `irq_req`, whatever the other bits and flags are.
- R3: With bit 7 set, enable bits 0..4 gate external 0, timer 0, external 1, timer 1 and serial. A request whose bit is 0 is never granted.
- R4: Flags are captured only on `latch_stb`, and arbitration happens only on `poll_stb`. A flag raised after the last latch is not seen by a poll. A latched flag is still served after its input has dropped.
- R5: Inside one level the lowest index wins (order: external 0, timer 0, external 1, timer 1, serial). The vectors are 0003h, 000Bh, 0013h, 001Bh and 0023h, that is 0003h + 8*index.
- R6: Priority bits 0..4 use the same source layout as the enable bits. A high-level request wins over every low-level request, and `irq_hi` reports the level of the granted request.
- R7: During low-level service only a high-level request is granted. During high-level service nothing is granted.
- R8: A `reti` pulse clears the high in-service flag if it is set, and otherwise clears the low one.
- R9: The serial receive and transmit flags each raise the serial request at vector 0023h. The controller never clears a flag, so a latched serial request is granted again after it has been served.
- R10: The bit addresses A8h+n and B8h+n write bit n of the enable and priority registers. Bits 5 and 6 of the enable register and bits 5..7 of the priority register always read 0 and ignore writes.
- R11: Once raised, `irq_req` stays high with a stable `irq_vec` until the cycle of `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_in | input | 1 | External request 0 flag |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| ext1_in | input | 1 | External request 1 flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| latch_stb | input | 1 | Sampling-point strobe, captures the flags |
| poll_stb | input | 1 | Poll strobe of the next machine cycle |
| sfr_we | input | 1 | Byte write enable |
| sfr_addr | input | 8 | Byte address for read and write |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Byte read data for `sfr_addr` |
| bit_we | input | 1 | Single-bit write enable |
| bit_addr | input | 8 | Bit address |
| bit_val | input | 1 | Bit write value |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Vector address of the granted request |
| irq_hi | output | 1 | Granted request is at the high level |
| irq_ack | input | 1 | Core accepts the request |
| reti | input | 1 | Return-from-interrupt pulse |

## Verification
Two functions can meet in the same cycle: a fresh arbitration on `poll_stb`, and the gating by the in-service state that an earlier `irq_ack` left behind. The bench grants a low-level request and acknowledges it. It then latches new requests at both levels and polls again, to confirm that only the high one passes. After that it works the `reti` pulses down one level at a time, and checks after each pulse whether a grant appears and which vector it carries. Two exhaustive sweeps cover all 32 enable masks and all 32 priority masks. The expected vector and level in each sweep come from the lowest qualifying index.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VIC_NSRC = 5;
    localparam int VIC_IW   = $clog2(VIC_NSRC);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } vic_state_e;
endpackage

// File: rtl/vic_regs.sv
module vic_regs #(
    parameter int         NSRC     = vic_pkg::VIC_NSRC,
    parameter logic [7:0] ADDR_EN  = 8'hA8,
    parameter logic [7:0] ADDR_PRI = 8'hB8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic            bit_we,
    input  logic [7:0]      bit_addr,
    input  logic            bit_val,
    output logic [NSRC-1:0] en_q,
    output logic            gen_q,
    output logic [NSRC-1:0] pri_q
);
    logic bit_en_hit, bit_pri_hit;
    assign bit_en_hit  = bit_we && (bit_addr[7:3] == ADDR_EN[7:3]);
    assign bit_pri_hit = bit_we && (bit_addr[7:3] == ADDR_PRI[7:3]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            gen_q <= 1'b0;
            pri_q <= '0;
        end else begin
            if (wr_en && addr == ADDR_EN) begin
                en_q  <= wdata[NSRC-1:0];
                gen_q <= wdata[7];
            end
            if (wr_en && addr == ADDR_PRI)
                pri_q <= wdata[NSRC-1:0];
            if (bit_en_hit) begin
                if (bit_addr[2:0] == 3'd7)
                    gen_q <= bit_val;
                else if (int'(bit_addr[2:0]) < NSRC)
                    en_q[bit_addr[2:0]] <= bit_val;
            end
            if (bit_pri_hit && int'(bit_addr[2:0]) < NSRC)
                pri_q[bit_addr[2:0]] <= bit_val;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_EN) begin
            rdata[NSRC-1:0] = en_q;
            rdata[7]        = gen_q;
        end else if (addr == ADDR_PRI) begin
            rdata[NSRC-1:0] = pri_q;
        end
    end
endmodule

// File: rtl/vic_latch.sv
module vic_latch #(
    parameter int NSRC = vic_pkg::VIC_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] lat
);
    always_ff @(posedge clk) begin
        if (!rst_n)   lat <= '0;
        else if (stb) lat <= raw;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(lat)); // R4
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
    parameter int NSRC = vic_pkg::VIC_NSRC,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lat,
    input  logic [NSRC-1:0] en,
    input  logic            gen,
    input  logic [NSRC-1:0] pri,
    input  logic            isv_hi,
    input  logic            isv_lo,
    output logic            pick_valid,
    output logic            pick_hi,
    output logic [IW-1:0]   pick_idx
);
    logic [NSRC-1:0] live, hi_set, lo_set;
    logic            hi_any, lo_any;
    logic [IW-1:0]   hi_idx, lo_idx;

    assign live   = gen ? (lat & en) : '0;
    assign hi_set = live & pri;
    assign lo_set = live & ~pri;

    always_comb begin
        hi_any = 1'b0; lo_any = 1'b0;
        hi_idx = '0;   lo_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hi_set[i]) begin hi_any = 1'b1; hi_idx = IW'(i); end
            if (lo_set[i]) begin lo_any = 1'b1; lo_idx = IW'(i); end
        end
    end

    always_comb begin
        pick_valid = 1'b0;
        pick_hi    = 1'b0;
        pick_idx   = '0;
        if (hi_any && !isv_hi) begin
            pick_valid = 1'b1;
            pick_hi    = 1'b1;
            pick_idx   = hi_idx;
        end else if (lo_any && !isv_hi && !isv_lo) begin
            pick_valid = 1'b1;
            pick_idx   = lo_idx;
        end
    end

    AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (gen && en[pick_idx] && lat[pick_idx])); // R3
    AST_PICK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (pri[pick_idx] == pick_hi)); // R6
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl #(
    parameter int          NSRC     = vic_pkg::VIC_NSRC,
    parameter logic [7:0]  ADDR_EN  = 8'hA8,
    parameter logic [7:0]  ADDR_PRI = 8'hB8,
    parameter logic [15:0] VEC_BASE = 16'h0003,
    parameter logic [15:0] VEC_STEP = 16'h0008
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext0_in,
    input  logic        tmr0_ovf,
    input  logic        ext1_in,
    input  logic        tmr1_ovf,
    input  logic        ser_rx_flag,
    input  logic        ser_tx_flag,
    input  logic        latch_stb,
    input  logic        poll_stb,
    input  logic        sfr_we,
    input  logic [7:0]  sfr_addr,
    input  logic [7:0]  sfr_wdata,
    output logic [7:0]  sfr_rdata,
    input  logic        bit_we,
    input  logic [7:0]  bit_addr,
    input  logic        bit_val,
    output logic        irq_req,
    output logic [15:0] irq_vec,
    output logic        irq_hi,
    input  logic        irq_ack,
    input  logic        reti
);
    import vic_pkg::*;
    localparam int IW = $clog2(NSRC);

    logic [NSRC-1:0] raw, lat, en, pri;
    logic            gen;
    logic            pick_valid, pick_hi;
    logic [IW-1:0]   pick_idx, idx_q;
    logic            hi_q, isv_hi, isv_lo;
    vic_state_e      state_q, state_d;

    assign raw = {ser_rx_flag | ser_tx_flag, tmr1_ovf, ext1_in, tmr0_ovf, ext0_in};

    vic_regs #(.NSRC(NSRC), .ADDR_EN(ADDR_EN), .ADDR_PRI(ADDR_PRI)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(sfr_we), .addr(sfr_addr),
        .wdata(sfr_wdata), .rdata(sfr_rdata), .bit_we(bit_we),
        .bit_addr(bit_addr), .bit_val(bit_val), .en_q(en), .gen_q(gen),
        .pri_q(pri)
    );

    vic_latch #(.NSRC(NSRC)) u_latch (
        .clk(clk), .rst_n(rst_n), .stb(latch_stb), .raw(raw), .lat(lat)
    );

    vic_arb #(.NSRC(NSRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .lat(lat), .en(en), .gen(gen), .pri(pri),
        .isv_hi(isv_hi), .isv_lo(isv_lo), .pick_valid(pick_valid),
        .pick_hi(pick_hi), .pick_idx(pick_idx)
    );

    // state register, captured winner and in-service flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            hi_q    <= 1'b0;
            isv_hi  <= 1'b0;
            isv_lo  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_REQ) begin
                idx_q <= pick_idx;
                hi_q  <= pick_hi;
            end
            if (reti) begin
                if (isv_hi) isv_hi <= 1'b0;
                else        isv_lo <= 1'b0;
            end
            if (state_q == ST_REQ && irq_ack) begin
                if (hi_q) isv_hi <= 1'b1;
                else      isv_lo <= 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        irq_req = 1'b0;
        unique case (state_q)
            ST_IDLE: if (poll_stb && pick_valid) state_d = ST_REQ;   // grant
            ST_REQ: begin
                irq_req = 1'b1;
                if (irq_ack) state_d = ST_IDLE;                      // accept
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign irq_hi  = hi_q;
    assign irq_vec = VEC_BASE + ({{(16-IW){1'b0}}, idx_q} * VEC_STEP);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec))); // R11
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !gen) |=> !irq_req); // R2
    AST_HI_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !isv_hi); // R7
    AST_LO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_hi) |-> !isv_lo); // R7
endmodule

// File: tb/vic_ctrl_test.sv
module vic_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] fl = '0;   // {tx, rx, tmr1, ext1, tmr0, ext0}
    logic latch_stb = 0, poll_stb = 0, sfr_we = 0, bit_we = 0, bit_val = 0;
    logic irq_ack = 0, reti = 0;
    logic [7:0] sfr_addr = '0, sfr_wdata = '0, bit_addr = '0;
    logic [7:0] sfr_rdata;
    logic irq_req, irq_hi;
    logic [15:0] irq_vec;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vic_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext0_in(fl[0]), .tmr0_ovf(fl[1]),
        .ext1_in(fl[2]), .tmr1_ovf(fl[3]), .ser_rx_flag(fl[4]),
        .ser_tx_flag(fl[5]), .latch_stb(latch_stb), .poll_stb(poll_stb),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .bit_we(bit_we), .bit_addr(bit_addr),
        .bit_val(bit_val), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_hi(irq_hi), .irq_ack(irq_ack), .reti(reti)
    );

    task automatic tick; @(posedge clk); @(negedge clk); endtask

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_we = 1; sfr_addr = a; sfr_wdata = d; tick; sfr_we = 0;
    endtask
    task automatic wbit(input logic [7:0] a, input logic v);
        bit_we = 1; bit_addr = a; bit_val = v; tick; bit_we = 0;
    endtask
    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a; #1 d = sfr_rdata;
    endtask
    task automatic latch; latch_stb = 1; tick; latch_stb = 0; endtask
    task automatic poll;  poll_stb = 1;  tick; poll_stb = 0;  endtask
    task automatic ack;   irq_ack = 1;   tick; irq_ack = 0;   endtask
    task automatic ret;   reti = 1;      tick; reti = 0;      endtask

    // expect a grant (exp_req) with vector/level; clears it afterwards if granted
    task automatic expect_grant(input bit exp_req, input int idx, input bit hi,
                                input string tag, input bit finish);
        chk(irq_req == exp_req, {tag, " req"}, irq_req, exp_req);
        if (exp_req) begin
            chk(irq_vec == 16'(3 + 8 * idx), {tag, " vec"}, irq_vec, 3 + 8 * idx);
            chk(irq_hi == hi, {tag, " level"}, irq_hi, hi);
        end
        if (irq_req && finish) begin ack; ret; end
    endtask

    function automatic int lowest(input logic [4:0] m);
        for (int i = 4; i >= 0; i--) if (m[i]) lowest = i;
        if (m == 0) lowest = 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) tick;
        rst_n = 1; tick;

        // R1 reset state
        rd(8'hA8, d); chk(d == 8'h00, "R1 enable reset", d, 0);
        rd(8'hB8, d); chk(d == 8'h00, "R1 priority reset", d, 0);
        chk(irq_req == 0, "R1 no request", irq_req, 0);

        // R2 global off: all flags, all enables but bit 7
        fl = 6'h3F; wr(8'hA8, 8'h1F); latch; poll;
        expect_grant(0, 0, 0, "R2 global off", 1);

        // R3/R5 sweep over enable masks, all flags up, one level
        for (int m = 0; m < 32; m++) begin
            wr(8'hA8, 8'h80 | 8'(m)); latch; poll;
            expect_grant(m != 0, lowest(5'(m)), 0, "R3 R5 enable sweep", 1);
        end

        // R6 sweep over priority masks, all enabled
        wr(8'hA8, 8'h9F);
        for (int p = 0; p < 32; p++) begin
            wr(8'hB8, 8'(p)); latch; poll;
            expect_grant(1, (p != 0) ? lowest(5'(p)) : 0, p != 0, "R6 priority sweep", 1);
        end
        wr(8'hB8, 8'h00);

        // R4 latch and poll timing
        fl = 6'h00; latch; fl = 6'h01; poll;
        expect_grant(0, 0, 0, "R4 unlatched flag", 1);
        latch; fl = 6'h00; poll;
        expect_grant(1, 0, 0, "R4 latched flag held", 1);

        // R9 shared serial vector and no hardware clear
        fl = 6'h10; latch; poll; expect_grant(1, 4, 0, "R9 rx", 0);
        ack; ret; fl = 6'h00; poll;
        expect_grant(1, 4, 0, "R9 rx not cleared", 1);
        fl = 6'h20; latch; poll; expect_grant(1, 4, 0, "R9 tx", 1);

        // R7/R8 nesting
        fl = 6'h01; latch; poll; expect_grant(1, 0, 0, "R7 low grant", 0);
        ack;
        fl = 6'h05; latch; poll; expect_grant(0, 0, 0, "R7 same level blocked", 0);
        wbit(8'hB9, 1'b1);
        fl = 6'h06; latch; poll; expect_grant(1, 1, 1, "R7 high preempts", 0);
        ack;
        fl = 6'h06; latch; poll; expect_grant(0, 0, 0, "R7 high in service blocks", 0);
        fl = 6'h04; latch; poll; expect_grant(0, 0, 0, "R7 low blocked by high", 0);
        ret; poll; expect_grant(0, 0, 0, "R8 low still in service", 0);
        ret; poll; expect_grant(1, 2, 0, "R8 both levels released", 1);

        // R10 bit writes and reserved bits
        wr(8'hA8, 8'h00); wr(8'hB8, 8'h00);
        wbit(8'hAF, 1'b1); rd(8'hA8, d); chk(d == 8'h80, "R10 bit write global", d, 8'h80);
        wbit(8'hAD, 1'b1); wbit(8'hAE, 1'b1); rd(8'hA8, d);
        chk(d == 8'h80, "R10 reserved enable bits", d, 8'h80);
        wbit(8'hAB, 1'b1); rd(8'hA8, d); chk(d == 8'h88, "R10 bit write enable 3", d, 8'h88);
        wr(8'hA8, 8'hFF); rd(8'hA8, d); chk(d == 8'h9F, "R10 byte write enable", d, 8'h9F);
        wr(8'hB8, 8'hFF); rd(8'hB8, d); chk(d == 8'h1F, "R10 byte write priority", d, 8'h1F);
        wbit(8'hBC, 1'b0); rd(8'hB8, d); chk(d == 8'h0F, "R10 bit clear priority 4", d, 8'h0F);

        // R11 request held without acknowledge
        fl = 6'h08; latch; poll; fl = 6'h00; latch;
        repeat (5) tick;
        expect_grant(1, 3, 1, "R11 held request", 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule